// File: doc/BRIEF.md
# Master-to-Frame Clock Ratio Detector

This block runs on the master audio clock and watches the frame (left/right) clock that arrives synchronous to it. It counts master-clock cycles from one rising frame edge to the next and classifies the result as one of five supported ratios. Ratios of 256, 384 and 512 select base-rate operation; 128 and 192 select high-rate operation. Any other period is reported as unsupported.

Once a ratio is qualified, the block produces two timing strobes for the serial receiver and the modulator that follow it. The first is an internal bit clock, realigned at every rising frame edge, whose rate per frame depends on both the measured ratio and the selected serial data format. The second is a modulator-rate tick at 128 times the frame rate in base-rate operation and 64 times in high-rate operation. Measurement repeats on every frame, so a change of master clock or sample rate is tracked without a reset.

Top module: `clkratio_det`

## Requirements
- R1: Each period is the number of master-clock cycles between two consecutive rising edges of `lrck`, where `lrck` is sampled on the rising edge of `mclk`.
- R2: A period is accepted as a supported ratio when it lies within 2 cycles of 128, 192, 256, 384 or 512. Anything else, including 3 cycles away, is a failed measurement.
- R3: `ratio_ok` rises only when a measurement is supported and equal to the previous measurement. It goes high in the cycle that directly follows the first cycle in which `lrck` is sampled high.
- R4: A failed measurement, or a supported one that differs from the previous one, clears `ratio_ok` at that edge. `ratio_code` reads 0, 1, 2, 3, 4 for ratios 128, 192, 256, 384, 512 while `ratio_ok` is high, and reads 7 otherwise.
- R5: `hi_rate` is high exactly when `ratio_ok` is high and the ratio is 128 or 192.
- R6: `bclk` has a period of N cycles and a 50% duty cycle. N is the ratio divided by the bit-clock multiple. Counting k = 0 from the first cycle after an `lrck` rising edge is taken, `bclk` is low for (k mod N) < N/2 and high otherwise. It is held low while `ratio_ok` is low.
- R7: The bit-clock multiple is 48 for ratios 192 and 384. For ratios 128, 256 and 512 it is 32 for `fmt` codes 0 and 2 (16-bit I2S, 16-bit right-justified) and 64 for codes 1 and 3 (left-justified, 18-bit right-justified). `fmt` is captured only at an `lrck` rising edge.
- R8: `bclk_tick` is high for one cycle, in the first high cycle of every `bclk` period.
- R9: `mod_tick` pulses once every ratio/128 cycles in base-rate operation and once every ratio/64 cycles in high-rate operation. The first pulse falls at k = 0, and the output stays low while `ratio_ok` is low.
- R10: If 1023 cycles pass without an `lrck` rising edge, `ratio_ok` is cleared. The next measurement then counts as the first one.
- R11: While `rst_n` is low, `ratio_ok`, `hi_rate`, `bclk`, `bclk_tick` and `mod_tick` are 0 and `ratio_code` is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Frame clock, synchronous to `mclk` |
| fmt | input | 2 | Serial data format code (see R7) |
| ratio_code | output | 3 | Qualified ratio code, 7 when not qualified |
| hi_rate | output | 1 | High-rate operation flag |
| ratio_ok | output | 1 | Ratio qualified by two matching measurements |
| bclk | output | 1 | Internal bit clock level |
| bclk_tick | output | 1 | One-cycle enable at each bit-clock rising point |
| mod_tick | output | 1 | One-cycle modulator-rate enable |

## Verification
The bench targets periods exactly 2 cycles off a legal ratio and exactly 3 cycles off. A window that is too narrow would never qualify the first kind, and one that is too wide would qualify the second. It switches ratio and checks that the qualification drops for one frame and comes back. A design that compared against the qualified ratio instead of the previous measurement would keep reporting stale codes. It changes `fmt` in the middle of a frame to catch a divider that picks up the new format before the next frame edge, and so produces a short bit-clock period. It also stops the frame clock entirely to catch a counter that wraps instead of saturating, which would qualify a silent input after a lucky wrap.

// File: rtl/crd_pkg.sv
package crd_pkg;

  localparam int NUM_RATIOS = 5;
  localparam int DIV_W      = 5;
  localparam int MOD_W      = 3;

  typedef enum logic [2:0] {
    RT_128  = 3'd0,
    RT_192  = 3'd1,
    RT_256  = 3'd2,
    RT_384  = 3'd3,
    RT_512  = 3'd4,
    RT_NONE = 3'd7
  } ratio_e;

  typedef enum logic [1:0] {
    FMT_I2S16 = 2'd0,
    FMT_LJ    = 2'd1,
    FMT_RJ16  = 2'd2,
    FMT_RJ18  = 2'd3
  } fmt_e;

  // Master cycles per frame for each code
  function automatic int ratio_value(ratio_e r);
    case (r)
      RT_128:  return 128;
      RT_192:  return 192;
      RT_256:  return 256;
      RT_384:  return 384;
      RT_512:  return 512;
      default: return 0;
    endcase
  endfunction

  // Master cycles per bit-clock period
  function automatic logic [DIV_W-1:0] bit_div(ratio_e r, logic wide);
    case (r)
      RT_128:  return wide ? DIV_W'(2) : DIV_W'(4);
      RT_192:  return DIV_W'(4);
      RT_256:  return wide ? DIV_W'(4) : DIV_W'(8);
      RT_384:  return DIV_W'(8);
      RT_512:  return wide ? DIV_W'(8) : DIV_W'(16);
      default: return DIV_W'(8);
    endcase
  endfunction

  // Master cycles per modulator tick
  function automatic logic [MOD_W-1:0] mod_div(ratio_e r);
    case (r)
      RT_192, RT_384: return MOD_W'(3);
      RT_512:         return MOD_W'(4);
      default:        return MOD_W'(2);
    endcase
  endfunction

endpackage

// File: rtl/crd_period_meas.sv
module crd_period_meas
  import crd_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lrck,
  output logic   frame_start,
  output ratio_e ratio,
  output logic   ok
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lrck_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  ratio_e           cand_q, cand_d;
  ratio_e           ratio_q, ratio_d;
  logic             ok_q, ok_d;
  ratio_e           meas_cls;

  assign frame_start = lrck & ~lrck_q;

  // Window match against every supported ratio
  always_comb begin
    meas_cls = RT_NONE;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if ((int'(cnt_q) >= ratio_value(ratio_e'(3'(i))) - TOL) &&
          (int'(cnt_q) <= ratio_value(ratio_e'(3'(i))) + TOL))
        meas_cls = ratio_e'(3'(i));
    end
  end

  always_comb begin
    cnt_d   = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    armed_d = armed_q;
    cand_d  = cand_q;
    ratio_d = ratio_q;
    ok_d    = ok_q;
    if (frame_start) begin
      cnt_d   = CNT_W'(1);
      armed_d = 1'b1;
      if (armed_q) begin
        if (meas_cls == RT_NONE) begin
          ok_d   = 1'b0;
          cand_d = RT_NONE;
        end else if (meas_cls == cand_q) begin
          ok_d    = 1'b1;
          ratio_d = meas_cls;
        end else begin
          ok_d   = 1'b0;
          cand_d = meas_cls;
        end
      end
    end else if (cnt_q == CNT_MAX) begin
      ok_d   = 1'b0;
      cand_d = RT_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_q  <= 1'b0;
      cnt_q   <= CNT_W'(1);
      armed_q <= 1'b0;
      cand_q  <= RT_NONE;
      ratio_q <= RT_NONE;
      ok_q    <= 1'b0;
    end else begin
      lrck_q  <= lrck;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      cand_q  <= cand_d;
      ratio_q <= ratio_d;
      ok_q    <= ok_d;
    end
  end

  assign ratio = ratio_q;
  assign ok    = ok_q;

endmodule

// File: rtl/crd_clk_gen.sv
module crd_clk_gen
  import crd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  ratio_e     ratio,
  input  logic       ok,
  input  logic [1:0] fmt,
  output logic       bclk,
  output logic       bclk_tick,
  output logic       mod_tick
);

  fmt_e             fmt_q, fmt_d;
  logic [DIV_W-1:0] bdiv_q, bdiv_d;
  logic [MOD_W-1:0] mdiv_q, mdiv_d;
  logic             wide;
  logic [DIV_W-1:0] n_bit, half_bit;
  logic [MOD_W-1:0] n_mod;

  assign wide     = (fmt_q == FMT_LJ) || (fmt_q == FMT_RJ18);
  assign n_bit    = bit_div(ratio, wide);
  assign half_bit = n_bit >> 1;
  assign n_mod    = mod_div(ratio);

  always_comb begin
    fmt_d  = fmt_q;
    bdiv_d = (bdiv_q >= n_bit - 1'b1) ? '0 : bdiv_q + 1'b1;
    mdiv_d = (mdiv_q >= n_mod - 1'b1) ? '0 : mdiv_q + 1'b1;
    if (frame_start) begin
      fmt_d  = fmt_e'(fmt);
      bdiv_d = '0;
      mdiv_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= FMT_I2S16;
      bdiv_q <= '0;
      mdiv_q <= '0;
    end else begin
      fmt_q  <= fmt_d;
      bdiv_q <= bdiv_d;
      mdiv_q <= mdiv_d;
    end
  end

  assign bclk      = ok && (bdiv_q >= half_bit);
  assign bclk_tick = ok && (bdiv_q == half_bit);
  assign mod_tick  = ok && (mdiv_q == '0);

endmodule

// File: rtl/clkratio_det.sv
module clkratio_det
  import crd_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       lrck,
  input  logic [1:0] fmt,
  output logic [2:0] ratio_code,
  output logic       hi_rate,
  output logic       ratio_ok,
  output logic       bclk,
  output logic       bclk_tick,
  output logic       mod_tick
);

  logic   frame_start;
  ratio_e ratio;
  logic   ok;

  crd_period_meas #(
    .CNT_W (CNT_W),
    .TOL   (TOL)
  ) i_meas (
    .clk         (mclk),
    .rst_n       (rst_n),
    .lrck        (lrck),
    .frame_start (frame_start),
    .ratio       (ratio),
    .ok          (ok)
  );

  crd_clk_gen i_gen (
    .clk         (mclk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .ratio       (ratio),
    .ok          (ok),
    .fmt         (fmt),
    .bclk        (bclk),
    .bclk_tick   (bclk_tick),
    .mod_tick    (mod_tick)
  );

  assign ratio_ok   = ok;
  assign ratio_code = ok ? ratio : RT_NONE;
  assign hi_rate    = ok && ((ratio == RT_128) || (ratio == RT_192));

endmodule

// File: rtl/clkratio_det_chk.sv
module clkratio_det_chk (
  input logic       mclk,
  input logic       rst_n,
  input logic       lrck,
  input logic [2:0] ratio_code,
  input logic       hi_rate,
  input logic       ratio_ok,
  input logic       bclk,
  input logic       bclk_tick
);

  // R5
  hi_rate_code_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    hi_rate |-> (ratio_code == 3'd0 || ratio_code == 3'd1));

  // R8
  bclk_tick_edge_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    bclk_tick |-> (bclk && !$past(bclk)));

  // R3
  ok_rise_on_frame_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(ratio_ok) |-> ($past(lrck) && !$past(lrck, 2)));

  // R4
  code_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (ratio_ok && $past(ratio_ok)) |-> $stable(ratio_code));

endmodule

bind clkratio_det clkratio_det_chk i_chk (
  .mclk       (mclk),
  .rst_n      (rst_n),
  .lrck       (lrck),
  .ratio_code (ratio_code),
  .hi_rate    (hi_rate),
  .ratio_ok   (ratio_ok),
  .bclk       (bclk),
  .bclk_tick  (bclk_tick)
);

// File: tb/test_clkratio_det.sv
module test_clkratio_det;

  localparam int CLK_NS = 8;
  localparam int SAT    = 1023;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrck = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [2:0] ratio_code;
  logic       hi_rate, ratio_ok, bclk, bclk_tick, mod_tick;

  always #(CLK_NS/2) mclk = ~mclk;

  clkratio_det i_clkratio_det (
    .mclk       (mclk),
    .rst_n      (rst_n),
    .lrck       (lrck),
    .fmt        (fmt),
    .ratio_code (ratio_code),
    .hi_rate    (hi_rate),
    .ratio_ok   (ratio_ok),
    .bclk       (bclk),
    .bclk_tick  (bclk_tick),
    .mod_tick   (mod_tick)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  int m_since, m_cand, m_cur, m_fmt;
  bit m_armed, m_ok, m_prev;

  function automatic int rval(int c);
    int vals[5] = '{128, 192, 256, 384, 512};
    return (c >= 0 && c < 5) ? vals[c] : 0;
  endfunction

  function automatic int classify(int p);
    for (int c = 0; c < 5; c++)
      if (p >= rval(c) - 2 && p <= rval(c) + 2) return c;
    return -1;
  endfunction

  function automatic int bit_n(int c, int f);
    int mult;
    if (c == 1 || c == 3) mult = 48;
    else if (f == 1 || f == 3) mult = 64;
    else mult = 32;
    return rval(c) / mult;
  endfunction

  function automatic int mod_n(int c);
    return (c < 2) ? rval(c) / 64 : rval(c) / 128;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge mclk) begin
    if (!rst_n) begin
      m_since = 0; m_cand = -1; m_cur = -1; m_fmt = 0;
      m_armed = 0; m_ok = 0; m_prev = 0;
    end else begin
      if (lrck && !m_prev) begin
        if (m_armed) begin
          int p;
          int c;
          p = (m_since + 1 > SAT) ? SAT : m_since + 1;
          c = classify(p);
          if (c < 0) begin m_ok = 0; m_cand = -1; end
          else if (c == m_cand) begin m_ok = 1; m_cur = c; end
          else begin m_ok = 0; m_cand = c; end
        end
        m_armed = 1;
        m_since = 0;
        m_fmt   = fmt;
      end else begin
        if (m_since + 1 >= SAT) begin m_ok = 0; m_cand = -1; end
        if (m_since < 100000) m_since++;
      end
      m_prev = lrck;
    end
  end

  // every-cycle comparison
  always @(negedge mclk) begin
    if (rst_n && !done) begin
      int n, mm;
      bit e_bclk, e_tick, e_mod;
      e_bclk = 0; e_tick = 0; e_mod = 0;
      if (m_ok) begin
        n  = bit_n(m_cur, m_fmt);
        mm = mod_n(m_cur);
        e_bclk = (m_since % n) >= n / 2;
        e_tick = (m_since % n) == n / 2;
        e_mod  = (m_since % mm) == 0;
      end
      chk("R3", "ratio_ok", ratio_ok, m_ok);
      chk("R4", "ratio_code", ratio_code, m_ok ? m_cur : 7);
      chk("R5", "hi_rate", hi_rate, m_ok && m_cur < 2);
      chk("R6", "bclk", bclk, e_bclk);
      chk("R8", "bclk_tick", bclk_tick, e_tick);
      chk("R9", "mod_tick", mod_tick, e_mod);
    end
  end

  task automatic run(int p, int n);
    for (int f = 0; f < n; f++)
      for (int c = 0; c < p; c++) begin
        @(posedge mclk);
        #1;
        lrck = (c < p / 2);
      end
  endtask

  task automatic mile(string req, bit eok, int ecode, bit ehi);
    @(negedge mclk);
    chk(req, "ratio_ok", ratio_ok, eok);
    chk(req, "ratio_code", ratio_code, ecode);
    chk(req, "hi_rate", hi_rate, ehi);
  endtask

  initial begin
    repeat (5) @(posedge mclk);
    @(negedge mclk);
    // R11 reset state
    chk("R11", "ratio_ok", ratio_ok, 0);
    chk("R11", "ratio_code", ratio_code, 7);
    chk("R11", "hi_rate", hi_rate, 0);
    chk("R11", "bclk", bclk, 0);
    chk("R11", "bclk_tick", bclk_tick, 0);
    chk("R11", "mod_tick", mod_tick, 0);
    rst_n = 1'b1;

    // R1 R3 base-rate qualification, 32x bit clock
    run(256, 4);  mile("R3", 1, 2, 0);
    run(512, 2);  mile("R4", 0, 7, 0);
    run(512, 1);  mile("R1", 1, 4, 0);
    run(128, 3);  mile("R5", 1, 0, 1);
    // R7 format changed mid-frame, applied at next frame edge
    fmt = 2'd1;
    run(128, 3);  mile("R7", 1, 0, 1);
    run(256, 3);  mile("R7", 1, 2, 0);
    run(512, 3);  mile("R7", 1, 4, 0);
    fmt = 2'd2;
    run(384, 4);  mile("R7", 1, 3, 0);
    fmt = 2'd3;
    run(192, 4);  mile("R5", 1, 1, 1);
    // R2 tolerance window
    run(254, 4);  mile("R2", 1, 2, 0);
    run(258, 4);  mile("R2", 1, 2, 0);
    run(190, 4);  mile("R2", 1, 1, 1);
    run(514, 4);  mile("R2", 1, 4, 0);
    run(259, 4);  mile("R2", 0, 7, 0);
    run(253, 4);  mile("R2", 0, 7, 0);
    run(300, 3);  mile("R2", 0, 7, 0);
    fmt = 2'd0;
    run(256, 4);  mile("R2", 1, 2, 0);
    for (int i = 0; i < 3; i++) begin
      run(256, 1);
      run(258, 1);
    end
    mile("R2", 1, 2, 0);
    // R10 frame clock stops
    repeat (1030) @(posedge mclk);
    mile("R10", 0, 7, 0);
    run(256, 2);  mile("R10", 0, 7, 0);
    run(256, 1);  mile("R10", 1, 2, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule